// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block generates the address sequence for a single DMA channel. Software programs a base address, a count and a signed step for the inner (element) dimension, and a count and a signed step for the outer (row) dimension. It then starts the channel by writing a control word. The generator presents one address at a time on a valid/ready stream and moves to the next address each time a transfer is accepted. Steps are counted in elements and are scaled by the programmed element width of 1, 2 or 4 bytes.

Within a row, the address moves by the inner step after each element. After the final element of a row, the outer step is used in place of the inner step. Because both steps are signed and independent, the outer step can be smaller than the inner step or negative. This lets the same buffer be walked in interleaved or de-interleaved order.

In one-shot mode, the channel stops after the final element. In circular mode, it reloads the base address and continues. A buffer-done pulse marks the end of every pass. An optional row pulse marks the end of every row.

Back-pressure rule: while `addr_valid` is high and `addr_ready` is low, the address holds steady and the channel does not advance. A transfer takes place on each rising clock edge where both signals are high. `addr_valid` is high exactly while the channel is running, and it does not depend on `addr_ready`.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `addr_valid`, `irq_row` and `irq_done` are low.
- R2: The channel is started by a write of a control word to select 5 with bit 0 set while the channel is idle. The other control bits are latched by the same write: bit 1 selects 2-D, bit 2 selects circular, bit 3 enables the row pulse, and bits 5:4 set the element width (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes). From the next cycle, `addr_valid` is high and `addr_out` equals the base address written at select 0.
- R3: Within a row, each accepted transfer adds the sign-extended 16-bit inner step (select 2), multiplied by the element width in bytes, to the address.
- R4: A transfer on the last element of a row, other than the last row, adds the signed outer step (select 4), multiplied by the element width, instead of the inner step. Element j of row r lies at base + (r·((ni−1)·si + so) + j·si)·width.
- R5: An inner count (select 1) or outer count (select 3) written as 0 means 65536.
- R6: In 1-D mode, the outer count is ignored and the buffer is a single row.
- R7: In one-shot mode, `addr_valid` is low in the cycle after the final transfer, and `irq_done` is high for exactly that one cycle.
- R8: In circular mode, the address after the final transfer is the base address again, the channel stays valid, and `irq_done` pulses for one cycle after every pass.
- R9: When the row pulse is enabled, `irq_row` is high for one cycle after the last transfer of every row. When it is disabled, `irq_row` stays low.
- R10: While `addr_valid` is high and `addr_ready` is low, `addr_out` and `addr_valid` hold on the next cycle.
- R11: While the channel runs, writes to selects 0 to 4 are ignored. A control write with bit 0 clear halts the channel, so `addr_valid` is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 base, 1 inner count, 2 inner step, 3 outer count, 4 outer step, 5 control |
| cfg_wdata | input | ADDR_W | Write data |
| addr_valid | output | 1 | Address available, high while running |
| addr_ready | input | 1 | Consumer accepts the current address |
| addr_out | output | ADDR_W | Current byte address |
| irq_row | output | 1 | One-cycle pulse after the last transfer of a row |
| irq_done | output | 1 | One-cycle pulse after the last transfer of a buffer pass |

## Verification
A wrong element or row index appears at the ports on the very next accepted transfer. It shows up as an address that breaks the closed-form position formula, or as a row or done pulse one element early or late. A wrong running flag shows up one cycle after the final transfer: `addr_valid` either stays high in one-shot mode or drops in circular mode. A corrupted current-address register during a stall shows up in the next cycle, because the held address must not move.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [2:0] {
    SEL_BASE  = 3'd0,
    SEL_ICNT  = 3'd1,
    SEL_ISTEP = 3'd2,
    SEL_OCNT  = 3'd3,
    SEL_OSTEP = 3'd4,
    SEL_CTRL  = 3'd5
  } cfg_sel_e;

  localparam int CTL_GO    = 0;
  localparam int CTL_TWO_D = 1;
  localparam int CTL_CIRC  = 2;
  localparam int CTL_ROWIE = 3;
  localparam int CTL_WIDTH = 4;
endpackage

// File: rtl/dma2d_regs.sv
module dma2d_regs import dma2d_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              running,
  output logic              go_pulse,
  output logic              halt_pulse,
  output logic [ADDR_W-1:0] base_q,
  output logic [CNT_W-1:0]  icnt_q,
  output logic [CNT_W-1:0]  istep_q,
  output logic [CNT_W-1:0]  ocnt_q,
  output logic [CNT_W-1:0]  ostep_q,
  output logic              two_d_q,
  output logic              circ_q,
  output logic              rowie_q,
  output logic [1:0]        width_q
);
  logic ctl_wr;
  assign ctl_wr     = cfg_we && (cfg_sel == SEL_CTRL);
  assign go_pulse   = ctl_wr && !running && cfg_wdata[CTL_GO];
  assign halt_pulse = ctl_wr && running && !cfg_wdata[CTL_GO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      icnt_q  <= '0;
      istep_q <= '0;
      ocnt_q  <= '0;
      ostep_q <= '0;
      two_d_q <= 1'b0;
      circ_q  <= 1'b0;
      rowie_q <= 1'b0;
      width_q <= 2'd0;
    end else if (cfg_we && !running) begin
      case (cfg_sel)
        SEL_BASE:  base_q  <= cfg_wdata;
        SEL_ICNT:  icnt_q  <= cfg_wdata[CNT_W-1:0];
        SEL_ISTEP: istep_q <= cfg_wdata[CNT_W-1:0];
        SEL_OCNT:  ocnt_q  <= cfg_wdata[CNT_W-1:0];
        SEL_OSTEP: ostep_q <= cfg_wdata[CNT_W-1:0];
        SEL_CTRL: begin
          two_d_q <= cfg_wdata[CTL_TWO_D];
          circ_q  <= cfg_wdata[CTL_CIRC];
          rowie_q <= cfg_wdata[CTL_ROWIE];
          width_q <= cfg_wdata[CTL_WIDTH+1:CTL_WIDTH];
        end
        default: ;
      endcase
    end
  end

  // R11
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && cfg_we && (cfg_sel != SEL_CTRL) |=> $stable(base_q) && $stable(icnt_q)
      && $stable(istep_q) && $stable(ocnt_q) && $stable(ostep_q));
endmodule

// File: rtl/dma2d_step_scale.sv
module dma2d_step_scale #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic [CNT_W-1:0]  step,
  input  logic [1:0]        width,
  output logic [ADDR_W-1:0] delta
);
  localparam int EXT_W = ADDR_W - CNT_W;
  logic [ADDR_W-1:0] ext;
  assign ext = {{EXT_W{step[CNT_W-1]}}, step};

  always_comb begin
    case (width)
      2'd0:    delta = ext;
      2'd1:    delta = ext << 1;
      default: delta = ext << 2;
    endcase
  end
endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              halt,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  icnt,
  input  logic [CNT_W-1:0]  ocnt,
  input  logic [ADDR_W-1:0] idelta,
  input  logic [ADDR_W-1:0] odelta,
  input  logic              two_d,
  input  logic              circ,
  input  logic              rowie,
  input  logic              ready,
  output logic              running,
  output logic [ADDR_W-1:0] cur,
  output logic              irq_row,
  output logic              irq_done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] eidx, ridx;
  logic last_elem, last_row, xfer;

  assign last_elem = (eidx == icnt - ONE);
  assign last_row  = !two_d || (ridx == ocnt - ONE);
  assign xfer      = running && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      cur      <= '0;
      eidx     <= '0;
      ridx     <= '0;
      irq_row  <= 1'b0;
      irq_done <= 1'b0;
    end else begin
      irq_row  <= 1'b0;
      irq_done <= 1'b0;
      if (go && !running) begin
        running <= 1'b1;
        cur     <= base;
        eidx    <= '0;
        ridx    <= '0;
      end else if (xfer) begin
        if (last_elem) begin
          irq_row <= rowie;
          eidx    <= '0;
          if (last_row) begin
            irq_done <= 1'b1;
            ridx     <= '0;
            cur      <= base;
            running  <= circ;
          end else begin
            ridx <= ridx + ONE;
            cur  <= cur + odelta;
          end
        end else begin
          eidx <= eidx + ONE;
          cur  <= cur + idelta;
        end
      end
      if (halt) running <= 1'b0;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && !ready && !halt |=> running && $stable(cur));
  // R7
  oneshot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done && !circ |-> !running);
  // R4
  elem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> eidx <= icnt - ONE);
  // R6
  one_d_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && !two_d |-> ridx == '0);
  // R9
  row_irq_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_row |-> rowie);
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr_out,
  output logic              irq_row,
  output logic              irq_done
);
  logic              go_pulse, halt_pulse, running;
  logic [ADDR_W-1:0] base_q, idelta, odelta;
  logic [CNT_W-1:0]  icnt_q, istep_q, ocnt_q, ostep_q;
  logic              two_d_q, circ_q, rowie_q;
  logic [1:0]        width_q;

  dma2d_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .running(running), .go_pulse(go_pulse),
    .halt_pulse(halt_pulse), .base_q(base_q), .icnt_q(icnt_q),
    .istep_q(istep_q), .ocnt_q(ocnt_q), .ostep_q(ostep_q),
    .two_d_q(two_d_q), .circ_q(circ_q), .rowie_q(rowie_q), .width_q(width_q)
  );

  dma2d_step_scale #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_iscale (
    .step(istep_q), .width(width_q), .delta(idelta)
  );

  dma2d_step_scale #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_oscale (
    .step(ostep_q), .width(width_q), .delta(odelta)
  );

  dma2d_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .go(go_pulse), .halt(halt_pulse),
    .base(base_q), .icnt(icnt_q), .ocnt(ocnt_q), .idelta(idelta),
    .odelta(odelta), .two_d(two_d_q), .circ(circ_q), .rowie(rowie_q),
    .ready(addr_ready), .running(running), .cur(addr_out),
    .irq_row(irq_row), .irq_done(irq_done)
  );

  assign addr_valid = running;
endmodule

// File: tb/tb_dma2d_addr_gen.sv
module tb_dma2d_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        addr_ready = 1'b0;
  logic        addr_valid, irq_row, irq_done;
  logic [31:0] addr_out;

  int n_chk = 0, n_fail = 0, cyc = 0, rp = 0;
  bit pend_row = 0, pend_done = 0, prev_stall = 0;
  logic [31:0] stall_addr = '0;

  dma2d_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr_out(addr_out), .irq_row(irq_row), .irq_done(irq_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check_irqs();
    chk(irq_row == pend_row, "R9", irq_row, pend_row);
    chk(irq_done == pend_done, "R7", irq_done, pend_done);
    pend_row = 0; pend_done = 0;
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    addr_ready = 1'b0;
    #1;
    check_irqs();
    prev_stall = 0;
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 32'(data);
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic step(input bit rdy, input logic [31:0] ea, input bit has_exp, output bit took);
    took = 0;
    @(negedge clk);
    addr_ready = rdy;
    #1;
    check_irqs();
    if (has_exp) begin
      chk(addr_valid, "R10", addr_valid, 1);
      if (prev_stall) chk(addr_out == stall_addr, "R10", addr_out, stall_addr);
      if (rdy) begin
        chk(addr_out == ea, "R4", addr_out, ea);
        took = 1;
      end
      prev_stall = !rdy;
      stall_addr = addr_out;
    end else prev_stall = 0;
  endtask

  task automatic run_buf(input logic [31:0] sa, input int ic, input int is, input int oc,
                         input int os, input int esz, input bit d2, input bit circ,
                         input bit rie, input int passes, input bit full_rdy);
    int ice, oce, szb;
    bit took, dummy;
    ice = (ic == 0) ? 65536 : ic;
    oce = d2 ? ((oc == 0) ? 65536 : oc) : 1;
    szb = 1 << ((esz > 2) ? 2 : esz);
    wr(0, sa); wr(1, ic); wr(2, is & 'hffff); wr(3, oc); wr(4, os & 'hffff);
    wr(5, 1 | (int'(d2) << 1) | (int'(circ) << 2) | (int'(rie) << 3) | (esz << 4));
    for (int p = 0; p < passes; p++)
      for (int r = 0; r < oce; r++)
        for (int j = 0; j < ice; j++) begin
          longint a;
          a = longint'(sa) + (longint'(r) * (longint'(ice - 1) * is + os) + longint'(j) * is) * szb;
          took = 0;
          while (!took) begin
            step(full_rdy ? 1'b1 : (rp % 3 != 2), a[31:0], 1'b1, took);
            rp++;
          end
          pend_row  = rie && (j == ice - 1);
          pend_done = (j == ice - 1) && (r == oce - 1);
          if (circ && p == 0 && r == 0 && j == 0) begin
            // R11: base rewrite while running must not move the restart point
            wr(0, int'(sa) + 'h1000);
          end
        end
    step(1'b0, '0, 1'b0, dummy);
    if (circ) begin
      chk(addr_valid && addr_out == sa, "R8", addr_out, sa);
      wr(5, 0);
      @(negedge clk); #1;
      chk(!addr_valid, "R11", addr_valid, 0);
    end else begin
      chk(!addr_valid, "R7", addr_valid, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1
    chk(!addr_valid && !irq_row && !irq_done, "R1", {addr_valid, irq_row, irq_done}, 0);

    // R2 R3 R4: sweep counts, signed steps, widths
    for (int ic = 1; ic <= 3; ic++)
      for (int oc = 1; oc <= 3; oc++)
        for (int si = 0; si < 3; si++)
          for (int so = 0; so < 3; so++)
            for (int w = 0; w < 3; w++) begin
              int isv, osv;
              isv = (si == 0) ? -3 : (si == 1) ? 1 : 4;
              osv = (so == 0) ? -7 : (so == 1) ? 0 : 5;
              run_buf(32'h0000_4000 + 32'(ic * 64), ic, isv, oc, osv, w, 1'b1, 1'b0,
                      1'((ic + oc) % 2), 1, 1'b0);
            end

    // R6: 1-D ignores outer count
    run_buf(32'h0001_0000, 4, 2, 3, 100, 1, 1'b0, 1'b0, 1'b1, 1, 1'b0);
    // R8: circular, three passes, row pulses
    run_buf(32'h0002_0000, 3, -1, 2, 9, 1, 1'b1, 1'b1, 1'b1, 3, 1'b0);
    // width code 3 behaves as 4 bytes (R3)
    run_buf(32'h0003_0000, 2, 3, 2, -2, 3, 1'b1, 1'b0, 1'b0, 1, 1'b0);
    // R5: count 0 means 65536
    run_buf(32'h0010_0000, 0, 1, 0, 0, 2, 1'b0, 1'b0, 1'b0, 1, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule